// File: doc/BRIEF.md
# BCD Watchdog Alarm Counter

This block is a four-digit BCD down counter for a timekeeping device. It counts in hundredths of a second, so it can be set anywhere from 0.01 s to 99.99 s. Software sets it up through a byte-wide register port. Every write goes to both the live counter and a seed register. Every read returns the live count and then restarts the count from the seed. A 100 Hz tick input drives the countdown.

When the countdown reaches zero, the block raises a sticky alarm flag. If reset steering is selected, it also asserts a reset request for a programmable number of system clocks. For that same window it asserts an access-inhibit output, and register traffic is ignored while that output is high.

With the enable input low, the two count bytes act as plain 16-bit storage. Writing zero while the counter is enabled parks it at zero without raising the alarm.

Top module: `wdog_bcd_alarm`

## Requirements
- R1: The count is BCD across two bytes. Byte select 0 is the low byte: bits [7:4] hold tenths and bits [3:0] hold hundredths. Byte select 1 is the high byte: bits [7:4] hold tens of seconds and bits [3:0] hold units of seconds.
- R2: An accepted write replaces the selected byte of the seed register. The whole counter is loaded from the updated seed at the same clock edge.
- R3: An accepted read places the selected byte of the count, as it was at that edge, on `reg_rdata` from the next cycle on. At the same edge the whole counter is reloaded from the seed. A write in the same cycle takes priority, and the read is then dropped.
- R4: With `count_en` high and a non-zero count, each `tick_100hz` cycle lowers the count by one hundredth. Borrows propagate through all four digits, so 10.00 becomes 09.99.
- R5: A tick that takes the count from non-zero to zero sets `alarm_flag` on the next cycle.
- R6: If `rst_steer` is high when the count reaches zero, `rst_req` and `access_block` are high for exactly PULSE_CLKS cycles, starting the cycle after. During that window, register writes, register reads and flag writes have no effect.
- R7: With `count_en` low, the count never changes on ticks. The two bytes read back exactly as written.
- R8: Writing zero into the count while `count_en` is high leaves the counter stopped at zero, and `alarm_flag` is not set.
- R9: A flag write of 0 clears `alarm_flag`. A flag write of 1 leaves it unchanged.
- R10: The counter holds at zero and does not wrap. It only runs again after a reload caused by a read or a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle pulse at 100 Hz |
| count_en | input | 1 | Counting enable; when low, the count bytes are plain storage |
| rst_steer | input | 1 | When high, expiry issues a reset pulse |
| reg_wr | input | 1 | Count byte write strobe |
| reg_rd | input | 1 | Count byte read strobe |
| reg_sel | input | SEL_W | Byte select (0 = low byte, 1 = high byte) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| flag_wr | input | 1 | Alarm flag write strobe |
| flag_wdata | input | 1 | Alarm flag write value |
| alarm_flag | output | 1 | Sticky expiry flag |
| rst_req | output | 1 | Reset request pulse |
| access_block | output | 1 | High while register access is inhibited |

## Verification
Some properties are checked on every cycle by assertions:
- a zero count stays at zero without a reload;
- a disabled counter holds its value;
- an enabled tick always changes a non-zero count;
- expiry is always followed by the flag;
- the flag only drops after an accepted clear;
- the read data holds while access is blocked;
- a finished pulse lasted exactly PULSE_CLKS cycles.

Other behaviours can only be shown by the bench's scenarios. These are the exact borrow chain from 10.00, the byte layout seen through reads, reload-on-read and seed retention, the silence of a zero write, and the dropping of writes and flag clears made during the pulse. A behavioural model in the bench covers them on every clock.

// File: rtl/wdog_alarm_pkg.sv
package wdog_alarm_pkg;
   typedef logic [3:0] bcd_digit_t;
   localparam bcd_digit_t BCD_TOP = 4'd9;
   localparam int unsigned BITS_PER_DIGIT = 4;
   localparam int unsigned DIGITS_PER_BYTE = 2;
endpackage

// File: rtl/wdog_bcd_digit_dec.sv
module wdog_bcd_digit_dec
   import wdog_alarm_pkg::*;
(
   input  bcd_digit_t din,
   input  logic       borrow_in,
   output bcd_digit_t dout,
   output logic       borrow_out
);
   always_comb begin
      borrow_out = borrow_in && (din == '0);
      if (!borrow_in)
         dout = din;
      else if (din == '0)
         dout = BCD_TOP;
      else
         dout = din - 4'd1;
   end
endmodule

// File: rtl/wdog_bcd_chain.sv
module wdog_bcd_chain
   import wdog_alarm_pkg::*;
#(
   parameter int DIGITS = 4,
   localparam int W = DIGITS * BITS_PER_DIGIT
) (
   input  logic [W-1:0] value,
   output logic [W-1:0] value_dec,
   output logic         is_zero
);
   logic [DIGITS:0] brw;
   assign brw[0] = 1'b1;

   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      wdog_bcd_digit_dec u_dig (
         .din       (value[BITS_PER_DIGIT*i +: BITS_PER_DIGIT]),
         .borrow_in (brw[i]),
         .dout      (value_dec[BITS_PER_DIGIT*i +: BITS_PER_DIGIT]),
         .borrow_out(brw[i+1])
      );
   end

   // a borrow that leaves the top digit means every digit was zero
   assign is_zero = brw[DIGITS];
endmodule

// File: rtl/wdog_count_core.sv
module wdog_count_core
   import wdog_alarm_pkg::*;
#(
   parameter int DIGITS = 4,
   parameter int SEL_W  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             wr_ok,
   input  logic             rd_ok,
   input  logic [SEL_W-1:0] sel,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic             expire
);
   localparam int W     = DIGITS * BITS_PER_DIGIT;
   localparam int BYTES = DIGITS / DIGITS_PER_BYTE;

   logic [W-1:0] count_q, seed_q, seed_n, count_dec;
   logic [7:0]   rd_byte;
   logic         cur_zero, load, step;

   wdog_bcd_chain #(.DIGITS(DIGITS)) u_chain (
      .value    (count_q),
      .value_dec(count_dec),
      .is_zero  (cur_zero)
   );

   assign load   = wr_ok | rd_ok;
   assign step   = en && tick && !cur_zero && !load;
   assign expire = step && (count_dec == '0);

   always_comb begin
      seed_n = seed_q;
      if (wr_ok) begin
         for (int b = 0; b < BYTES; b++) begin
            if (sel == SEL_W'(b)) seed_n[8*b +: 8] = wdata;
         end
      end
   end

   if (BYTES == 1) begin : g_one_byte
      assign rd_byte = count_q[7:0];
   end else begin : g_multi_byte
      always_comb begin
         rd_byte = count_q[7:0];
         for (int b = 0; b < BYTES; b++) begin
            if (sel == SEL_W'(b)) rd_byte = count_q[8*b +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         seed_q  <= '0;
         rdata   <= '0;
      end else begin
         if (load) begin
            count_q <= seed_n;
            seed_q  <= seed_n;
         end else if (step) begin
            count_q <= count_dec;
         end
         if (rd_ok && !wr_ok) rdata <= rd_byte;
      end
   end

   p_stop_at_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_zero && !load) |=> cur_zero);
   p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(count_q));
   p_tick_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !cur_zero && !load) |=> (count_q != $past(count_q)));
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
   parameter int PULSE_CLKS = 20,
   localparam int CW = $clog2(PULSE_CLKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   if (PULSE_CLKS == 1) begin : g_single
      logic on_q;
      always_ff @(posedge clk) begin
         if (!rst_n) on_q <= 1'b0;
         else        on_q <= start;
      end
      assign active = on_q;
   end else begin : g_counted
      logic [CW-1:0] remain_q, run_q;
      always_ff @(posedge clk) begin
         if (!rst_n)              remain_q <= '0;
         else if (start)          remain_q <= CW'(PULSE_CLKS);
         else if (remain_q != '0) remain_q <= remain_q - 1'b1;
      end
      assign active = (remain_q != '0);

      // elapsed-cycle count, used only to check the pulse width
      always_ff @(posedge clk) begin
         if (!rst_n || !active) run_q <= '0;
         else                   run_q <= run_q + 1'b1;
      end

      p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(active) |-> ($past(run_q) == CW'(PULSE_CLKS - 1)));
   end
endmodule

// File: rtl/wdog_bcd_alarm.sv
module wdog_bcd_alarm #(
   parameter int DIGITS     = 4,
   parameter int PULSE_CLKS = 20,
   localparam int BYTES = DIGITS / 2,
   localparam int SEL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_100hz,
   input  logic             count_en,
   input  logic             rst_steer,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [SEL_W-1:0] reg_sel,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             flag_wr,
   input  logic             flag_wdata,
   output logic             alarm_flag,
   output logic             rst_req,
   output logic             access_block
);
   if (DIGITS < 2 || (DIGITS % 2) != 0) begin : g_bad_digits
      $error("DIGITS must be an even number of at least 2");
   end
   if (PULSE_CLKS < 1) begin : g_bad_pulse
      $error("PULSE_CLKS must be at least 1");
   end

   logic wr_ok, rd_ok, flag_clr, expire, pulse_on;

   assign wr_ok    = reg_wr & ~access_block;
   assign rd_ok    = reg_rd & ~access_block;
   assign flag_clr = flag_wr & ~flag_wdata & ~access_block;

   wdog_count_core #(.DIGITS(DIGITS), .SEL_W(SEL_W)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_100hz),
      .en    (count_en),
      .wr_ok (wr_ok),
      .rd_ok (rd_ok),
      .sel   (reg_sel),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .expire(expire)
   );

   wdog_pulse_gen #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .start (expire & rst_steer),
      .active(pulse_on)
   );

   assign rst_req      = pulse_on;
   assign access_block = pulse_on;

   always_ff @(posedge clk) begin
      if (!rst_n)        alarm_flag <= 1'b0;
      else if (expire)   alarm_flag <= 1'b1;
      else if (flag_clr) alarm_flag <= 1'b0;
   end

   p_flag_on_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> alarm_flag);
   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !flag_clr) |=> alarm_flag);
   p_blocked_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      access_block |=> $stable(reg_rdata));
endmodule

// File: tb/wdog_bcd_alarm_test.sv
`timescale 1ns/1ps
module wdog_bcd_alarm_test;
   localparam int PULSE = 20;
   localparam int LIMIT = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_100hz = 1'b0, count_en = 1'b0, rst_steer = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [0:0] reg_sel = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic flag_wr = 1'b0, flag_wdata = 1'b0;
   logic alarm_flag, rst_req, access_block;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdog_bcd_alarm #(.DIGITS(4), .PULSE_CLKS(PULSE)) uut (
      .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .count_en(count_en),
      .rst_steer(rst_steer), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag_wr(flag_wr),
      .flag_wdata(flag_wdata), .alarm_flag(alarm_flag), .rst_req(rst_req),
      .access_block(access_block)
   );

   // behavioural reference model
   int         m_cnt;
   logic [15:0] m_seed;
   logic [7:0] m_rd;
   bit         m_flag;
   int         m_pulse;
   bit         m_acc, m_exp;
   logic [15:0] m_tmp;

   function automatic logic [15:0] to_bcd(int v);
      return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
   endfunction

   function automatic int from_bcd(logic [15:0] b);
      return int'(b[15:12]) * 1000 + int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_seed = '0; m_rd = '0; m_flag = 0; m_pulse = 0;
      end else begin
         m_acc = (m_pulse == 0);
         m_exp = 0;
         if (m_acc && reg_wr) begin
            if (reg_sel[0]) m_seed[15:8] = reg_wdata;
            else            m_seed[7:0]  = reg_wdata;
            m_cnt = from_bcd(m_seed);
         end else if (m_acc && reg_rd) begin
            m_tmp = to_bcd(m_cnt);
            m_rd  = reg_sel[0] ? m_tmp[15:8] : m_tmp[7:0];
            m_cnt = from_bcd(m_seed);
         end else if (count_en && tick_100hz && m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) m_exp = 1;
         end
         if (m_exp) m_flag = 1;
         else if (m_acc && flag_wr && !flag_wdata) m_flag = 0;
         if (m_pulse > 0) m_pulse = m_pulse - 1;
         if (m_exp && rst_steer) m_pulse = PULSE;
      end
   end

   task automatic ck(int act, int exp, string tag);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         ck(int'(reg_rdata), int'(m_rd), "R3 model rdata");
         ck(int'(alarm_flag), int'(m_flag), "R5 model flag");
         ck(int'(rst_req), int'(m_pulse > 0), "R6 model rst_req");
         ck(int'(access_block), int'(m_pulse > 0), "R6 model access_block");
      end
   end

   task automatic wr(bit sel, logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_chk(bit sel, logic [7:0] exp, string tag);
      @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
      @(negedge clk); reg_rd = 1'b0;
      ck(int'(reg_rdata), int'(exp), tag);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_100hz = 1'b1;
         @(negedge clk); tick_100hz = 1'b0;
      end
   endtask

   task automatic fwr(bit v);
      @(negedge clk); flag_wr = 1'b1; flag_wdata = v;
      @(negedge clk); flag_wr = 1'b0;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      int nb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      ck(int'(reg_rdata), 0, "R3 reset rdata");
      ck(int'(alarm_flag), 0, "R5 reset flag");
      ck(int'(access_block), 0, "R6 reset block");

      // R7: disabled counter is plain storage
      wr(1'b0, 8'h34); wr(1'b1, 8'h12);
      ticks(5);
      rd_chk(1'b0, 8'h34, "R7 low byte kept");
      rd_chk(1'b1, 8'h12, "R7 high byte kept");

      // R4 borrow across all digits, R3 reload, R1 layout
      wr(1'b1, 8'h10); wr(1'b0, 8'h00);
      @(negedge clk); count_en = 1'b1;
      ticks(1);
      rd_chk(1'b0, 8'h99, "R4 10.00 to 09.99 low");
      rd_chk(1'b1, 8'h10, "R3 reload from seed");
      ticks(1);
      rd_chk(1'b1, 8'h09, "R1 high byte units");

      // R5 expiry without steering, R10 no wrap
      wr(1'b1, 8'h00); wr(1'b0, 8'h03);
      ticks(3);
      ck(int'(alarm_flag), 1, "R5 flag on expiry");
      ck(int'(access_block), 0, "R6 no pulse unsteered");
      ticks(2);
      rd_chk(1'b0, 8'h00, "R10 held at zero");
      rd_chk(1'b0, 8'h03, "R2 seed reused");
      @(negedge clk); count_en = 1'b0;

      // R9 flag write semantics
      fwr(1'b1);
      ck(int'(alarm_flag), 1, "R9 write one keeps");
      fwr(1'b0);
      ck(int'(alarm_flag), 0, "R9 write zero clears");

      // R8 zero write while enabled
      @(negedge clk); count_en = 1'b1;
      wr(1'b0, 8'h00);
      ticks(3);
      ck(int'(alarm_flag), 0, "R8 no flag on zero write");
      rd_chk(1'b0, 8'h00, "R8 stays zero");

      // R6 steered pulse and blocked access
      @(negedge clk); rst_steer = 1'b1;
      wr(1'b0, 8'h02);
      ticks(1);
      @(negedge clk); tick_100hz = 1'b1;
      @(negedge clk); tick_100hz = 1'b0;
      nb = access_block ? 1 : 0;
      reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h55;
      flag_wr = 1'b1; flag_wdata = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         reg_wr = 1'b0; flag_wr = 1'b0;
         if (access_block) nb++;
      end
      ck(nb, PULSE, "R6 pulse width");
      ck(int'(alarm_flag), 1, "R6 blocked flag clear ignored");
      rd_chk(1'b0, 8'h00, "R6 blocked write ignored");
      rd_chk(1'b0, 8'h02, "R2 seed intact");
      @(negedge clk); rst_steer = 1'b0; count_en = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end
endmodule